// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets logic in a synchronous clock domain read and write one external asynchronous static RAM of 256K bytes. The host raises a request together with a read/write select, an 18-bit word address and, for writes, a data byte. The block captures these values, then drives the memory's address, its two chip selects (one active-low and one active-high), its write and output strobes, and the three signals of a shared tri-state byte bus. When the access is complete it raises a one-cycle done pulse. Read data is returned on a registered output.

Every phase of an access lasts a whole number of clock cycles. Each length is derived at elaboration by ceiling division of a nanosecond figure (strobe width, data setup, cycle time, bus release) by the clock period. A timing grade or clock change therefore only needs new parameter values. Between accesses both chip selects are inactive and the bus is released, so the memory drops into its own low-power standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever idle, `memSelN`=1, `memSelP`=0, `memWeN`=1, `memOeN`=1, `memDoutEn`=0, `hostReady`=1 and `hostDone`=0. `hostRdata` resets to 0.
- R2: A write takes one setup cycle with both selects active and `memWeN` high, then `memWeN` low for WP cycles, then one hold cycle with `memWeN` high and `hostDone` high. WP is the largest of ceil(45 ns/T), ceil(25 ns/T) and ceil(55 ns/T)-2, where T is the clock period.
- R3: Throughout a write, `memOeN` stays high and `memDoutEn` is high with `memDout` equal to the accepted byte. The bus is never driven while `memOeN` is low.
- R4: A read holds both selects active, `memWeN` high and `memOeN` low for RD = ceil(55 ns/T) cycles, and does not drive the bus.
- R5: The byte on `memDin` is captured at the end of the last read cycle. It appears on `hostRdata` in the cycle where `hostDone` is high, which is the cycle after `memOeN` rises.
- R6: After a read, `hostReady` stays low for TURN = ceil(25 ns/T) further cycles with the selects inactive. The bus is not driven again until at least TURN cycles after `memOeN` rose.
- R7: Each access raises `hostDone` for exactly one cycle.
- R8: A request is taken only in a cycle where `hostReady` is high. A request raised while an access is in progress has no effect.
- R9: Address and write data are registered when the request is taken. `memAddr` and `memDout` stay constant for the whole access even if the host inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Access request, sampled while ready |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 18 | Word address |
| hostWdata | input | 8 | Byte to write |
| hostRdata | output | 8 | Last byte read |
| hostDone | output | 1 | One-cycle completion pulse |
| hostReady | output | 1 | Idle, a request will be taken |
| memAddr | output | 18 | Memory address bus |
| memSelN | output | 1 | Active-low chip select |
| memSelP | output | 1 | Active-high chip select |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | 8 | Byte driven onto the data bus |
| memDoutEn | output | 1 | Drive enable for the data bus |
| memDin | input | 8 | Byte sampled from the data bus |

## Verification
The case of interest is the end of a read running into the start of a write. The read's done pulse and a pending write request fall in the same cycle while the memory may still be driving the bus. The bench provokes this by holding the request high across a read and switching it to a write in the done cycle. It then judges the outcome by counting cycles from the rise of the output enable to the rise of the bus drive, which must be TURN+1. It also checks that the write still completes and reads back correctly.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS,
    ST_RTURN
  } phase_t;

  typedef struct packed {
    logic latchReq;
    logic selMem;
    logic weOn;
    logic oeOn;
    logic driveBus;
    logic captureRd;
    logic donePulse;
  } sramStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int WP_CYC   = 5,
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic        writeSel,
  output sramStrobe_t strobe,
  output logic        readyOut
);

  localparam int LONGEST = maxOf(maxOf(WP_CYC, RD_CYC), TURN_CYC);
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] WP_LAST   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] RD_LAST   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);

  phase_t          phaseQ, phaseD;
  logic [CW-1:0]   cntQ, cntD;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ + 1'b1;
    case (phaseQ)
      ST_IDLE: begin
        cntD = '0;
        if (reqIn) phaseD = writeSel ? ST_WSETUP : ST_RACCESS;
      end
      ST_WSETUP: begin
        phaseD = ST_WPULSE;
        cntD   = '0;
      end
      ST_WPULSE: begin
        if (cntQ == WP_LAST) begin
          phaseD = ST_WHOLD;
          cntD   = '0;
        end
      end
      ST_WHOLD: begin
        phaseD = ST_IDLE;
        cntD   = '0;
      end
      ST_RACCESS: begin
        if (cntQ == RD_LAST) begin
          phaseD = ST_RTURN;
          cntD   = '0;
        end
      end
      ST_RTURN: begin
        if (cntQ == TURN_LAST) begin
          phaseD = ST_IDLE;
          cntD   = '0;
        end
      end
      default: begin
        phaseD = ST_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.latchReq  = (phaseQ == ST_IDLE) && reqIn;
    strobe.selMem    = (phaseQ == ST_WSETUP) || (phaseQ == ST_WPULSE) ||
                       (phaseQ == ST_WHOLD)  || (phaseQ == ST_RACCESS);
    strobe.weOn      = (phaseQ == ST_WPULSE);
    strobe.oeOn      = (phaseQ == ST_RACCESS);
    strobe.driveBus  = (phaseQ == ST_WSETUP) || (phaseQ == ST_WPULSE) ||
                       (phaseQ == ST_WHOLD);
    strobe.captureRd = (phaseQ == ST_RACCESS) && (cntQ == RD_LAST);
    strobe.donePulse = (phaseQ == ST_WHOLD) ||
                       ((phaseQ == ST_RTURN) && (cntQ == '0));
  end

  assign readyOut = (phaseQ == ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.donePulse |=> !strobe.donePulse); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchReq |=> !readyOut); // R8

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobe_t       strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (strobe.captureRd) rdataQ <= memDin;
  end

  assign memAddr   = addrQ;
  assign memSelN   = ~strobe.selMem;
  assign memSelP   = strobe.selMem;
  assign memWeN    = ~strobe.weOn;
  assign memOeN    = ~strobe.oeOn;
  assign memDout   = wdataQ;
  assign memDoutEn = strobe.driveBus;
  assign hostRdata = rdataQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memSelN && $past(!memSelN)) |-> $stable(memAddr)); // R9

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout)); // R9

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_WPULSE_NS   = 45,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_WCYCLE_NS   = 55,
  parameter int T_RCYCLE_NS   = 55,
  parameter int T_RELEASE_NS  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic              hostReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int WP_CYC = maxOf(maxOf(nsToCycles(T_WPULSE_NS, CLK_PERIOD_PS),
                                      nsToCycles(T_DSETUP_NS, CLK_PERIOD_PS)),
                                nsToCycles(T_WCYCLE_NS, CLK_PERIOD_PS) - 2);
  localparam int RD_CYC   = maxOf(nsToCycles(T_RCYCLE_NS, CLK_PERIOD_PS), 1);
  localparam int TURN_CYC = maxOf(nsToCycles(T_RELEASE_NS, CLK_PERIOD_PS), 1);
  localparam int LONGEST  = maxOf(maxOf(WP_CYC, RD_CYC), TURN_CYC);
  localparam int CNTW     = $clog2(LONGEST + 2);

  sramStrobe_t strobe;

  sramc_ctrl #(
    .WP_CYC  (WP_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (hostReq),
    .writeSel(hostWrite),
    .strobe  (strobe),
    .readyOut(hostReady)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memSelN  (memSelN),
    .memSelP  (memSelP),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memDin   (memDin)
  );

  assign hostDone = strobe.donePulse;

  // Pin-level width counters used by the timing checks below.
  logic [CNTW-1:0] weLowCnt, oeLowCnt, sinceOeHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt    <= '0;
      oeLowCnt    <= '0;
      sinceOeHigh <= '1;
    end else begin
      weLowCnt    <= memWeN ? '0 : ((weLowCnt == '1) ? weLowCnt : weLowCnt + 1'b1);
      oeLowCnt    <= memOeN ? '0 : ((oeLowCnt == '1) ? oeLowCnt : oeLowCnt + 1'b1);
      sinceOeHigh <= !memOeN ? '0 :
                     ((sinceOeHigh == '1) ? sinceOeHigh : sinceOeHigh + 1'b1);
    end
  end

  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (memSelN && !memSelP && memWeN && memOeN && !memDoutEn)); // R1

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == CNTW'(WP_CYC))); // R2

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && memDoutEn)); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoutEn); // R3

  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowCnt == CNTW'(RD_CYC))); // R4

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> hostDone); // R5

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoutEn) |-> (sinceOeHigh >= CNTW'(TURN_CYC))); // R6

endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;

  localparam int PERIOD_PS = 8000;

  function automatic int ceilDiv(input int ns);
    return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  endfunction

  localparam int WP_A  = (ceilDiv(45) > ceilDiv(25)) ? ceilDiv(45) : ceilDiv(25);
  localparam int WP_E  = (WP_A > ceilDiv(55) - 2) ? WP_A : ceilDiv(55) - 2;
  localparam int RD_E  = ceilDiv(55);
  localparam int TRN_E = ceilDiv(25);

  typedef struct packed {
    logic        wr;
    logic [17:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 18'h00000, 8'hA5},
    '{1'b1, 18'h3FFFF, 8'h5A},
    '{1'b1, 18'h12345, 8'hFF},
    '{1'b0, 18'h00000, 8'hA5},
    '{1'b0, 18'h3FFFF, 8'h5A},
    '{1'b0, 18'h12345, 8'hFF},
    '{1'b1, 18'h12345, 8'h00},
    '{1'b0, 18'h12345, 8'h00},
    '{1'b1, 18'h20001, 8'h81},
    '{1'b0, 18'h20001, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [17:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        hostDone, hostReady;
  logic [17:0] memAddr;
  logic        memSelN, memSelP, memWeN, memOeN, memDoutEn;
  logic [7:0]  memDout;
  wire  [7:0]  memDin;

  int totalChecks = 0;
  int badChecks   = 0;

  always #4ns clk = ~clk;

  async_sram_ctrl #(.CLK_PERIOD_PS(PERIOD_PS)) dut (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostDone(hostDone),
    .hostReady(hostReady), .memAddr(memAddr), .memSelN(memSelN),
    .memSelP(memSelP), .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // Behavioural memory on the pin side
  logic [7:0] modelMem [int];
  logic [7:0] modelOut = '0;

  always @(posedge memWeN)
    if (memSelN === 1'b0 && memSelP === 1'b1 && memDoutEn === 1'b1)
      modelMem[int'(memAddr)] = memDout;

  always @(negedge clk)
    modelOut = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : 8'h00;

  assign memDin = (!memSelN && memSelP && memWeN && !memOeN) ? modelOut : 8'hzz;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-access observations
  int busy, weLow, oeLow, doneCnt, doneAt, addrMoves, busBad, oeInWrite;
  logic [7:0] rdSeen;

  task automatic runAccess(input bit wr, input logic [17:0] a, input logic [7:0] d,
                           input bit poke);
    int k;
    busy = 0; weLow = 0; oeLow = 0; doneCnt = 0; doneAt = 0;
    addrMoves = 0; busBad = 0; oeInWrite = 0; rdSeen = '0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 1'b0; hostAddr = a ^ 18'h15555; hostWdata = ~d;
    k = 1;
    while (!hostReady && k < 1000) begin
      if (!memWeN) weLow++;
      if (!memOeN) oeLow++;
      if (hostDone) begin doneCnt++; doneAt = k; rdSeen = hostRdata; end
      if (memAddr != a) addrMoves++;
      if (wr && !memOeN) oeInWrite++;
      if (wr && (!memDoutEn || memDout != d)) busBad++;
      if (!wr && memDoutEn) busBad++;
      if (memSelN || !memSelP) begin
        if (wr || k <= RD_E) busBad++;
      end
      if (poke && k == 3) begin
        hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 18'h2AAAA; hostWdata = 8'h77;
      end
      if (poke && k == 4) hostReq = 1'b0;
      k++;
      @(negedge clk);
    end
    busy = k - 1;
  endtask

  task automatic judge(input bit wr, input logic [7:0] d);
    if (wr) begin
      check(weLow == WP_E, "R2 write strobe width", weLow, WP_E);
      check(busy == WP_E + 2, "R2 write length", busy, WP_E + 2);
      check(doneAt == WP_E + 2, "R2 done in hold cycle", doneAt, WP_E + 2);
      check(oeInWrite == 0, "R3 oe high during write", oeInWrite, 0);
    end else begin
      check(oeLow == RD_E, "R4 read strobe width", oeLow, RD_E);
      check(weLow == 0, "R4 no write strobe in read", weLow, 0);
      check(doneAt == RD_E + 1, "R5 done after oe rises", doneAt, RD_E + 1);
      check(rdSeen == d, "R5 read data", rdSeen, d);
      check(busy == RD_E + TRN_E, "R6 read busy incl release", busy, RD_E + TRN_E);
    end
    check(busBad == 0, "R3 bus and select pattern", busBad, 0);
    check(doneCnt == 1, "R7 single done", doneCnt, 1);
    check(addrMoves == 0, "R9 address held", addrMoves, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    badChecks++;
    totalChecks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

  initial begin : main
    int oeRiseK, drvRiseK, dones, k, secondDoneK;
    bit sawOeLow;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(memSelN && !memSelP && memWeN && memOeN && !memDoutEn,
          "R1 pins parked at reset", {memSelN, memSelP, memWeN, memOeN, memDoutEn}, 5'b10110);
    check(hostReady && !hostDone, "R1 ready without done",
          {hostReady, hostDone}, 2'b10);
    check(hostRdata == 8'h00, "R1 read data reset", hostRdata, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady && memSelN && !memSelP, "R1 idle after release",
          {hostReady, memSelN, memSelP}, 3'b110);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      runAccess(VECS[i].wr, VECS[i].a, VECS[i].d, 1'b0);
      judge(VECS[i].wr, VECS[i].d);
      check(memSelN && !memSelP && memWeN && memOeN && !memDoutEn,
            "R1 parked between accesses",
            {memSelN, memSelP, memWeN, memOeN, memDoutEn}, 5'b10110);
    end

    // R8: request raised mid-write is ignored
    runAccess(1'b1, 18'h01010, 8'hC3, 1'b1);
    judge(1'b1, 8'hC3);
    repeat (3) @(negedge clk);
    check(hostReady && !hostDone, "R8 no second access started",
          {hostReady, hostDone}, 2'b10);
    runAccess(1'b0, 18'h2AAAA, 8'h00, 1'b0);
    check(rdSeen == 8'h00, "R8 ignored write left memory", rdSeen, 0);
    runAccess(1'b0, 18'h01010, 8'hC3, 1'b0);
    check(rdSeen == 8'hC3, "R8 accepted write stored", rdSeen, 8'hC3);

    // R6/R8: read followed at once by a write with request held high
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 18'h3FFFF; hostWdata = 8'h00;
    @(negedge clk);
    k = 1; oeRiseK = 0; drvRiseK = 0; dones = 0; sawOeLow = 0; secondDoneK = 0;
    while (dones < 2 && k < 200) begin
      if (!memOeN) sawOeLow = 1;
      if (sawOeLow && memOeN && oeRiseK == 0) oeRiseK = k;
      if (memDoutEn && drvRiseK == 0) drvRiseK = k;
      if (hostDone) begin
        dones++;
        if (dones == 1) begin
          check(hostRdata == 8'h5A, "R5 read before write", hostRdata, 8'h5A);
          hostWrite = 1'b1; hostAddr = 18'h0ABCD; hostWdata = 8'h3C;
        end else begin
          secondDoneK = k;
          hostReq = 1'b0;
        end
      end
      k++;
      @(negedge clk);
    end
    check(oeRiseK == RD_E + 1, "R6 oe release cycle", oeRiseK, RD_E + 1);
    check(drvRiseK - oeRiseK == TRN_E + 1, "R6 bus turnaround gap",
          drvRiseK - oeRiseK, TRN_E + 1);
    check(secondDoneK == RD_E + TRN_E + WP_E + 3, "R8 write waits for idle",
          secondDoneK, RD_E + TRN_E + WP_E + 3);
    runAccess(1'b0, 18'h0ABCD, 8'h3C, 1'b0);
    check(rdSeen == 8'h3C, "R6 back-to-back write stored", rdSeen, 8'h3C);

    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule